// File: doc/BRIEF.md
# Interference-Gated Miss-Slot Throttle

This controller decides, once per evaluation interval, whether one processor in a multicore cluster should lose a miss-handling slot. For every ordered pair of an interfering processor and a delayed processor it reads one interference score. When a new evaluation is requested, it walks through all of these scores one per cycle and finds the largest. It then compares that peak with a programmable ceiling.

A peak above the ceiling does not cause a reduction straight away. The controller keeps the pair that caused the previous excess and a small repeat count. A reduction happens only when the same pair stays above the ceiling in enough evaluations in a row, as set by a programmable repeat threshold. A reduction is issued as a one-cycle write to the culprit processor. The write carries a new limit that is one below the limit currently reported for that processor, and never less than one. Other logic keeps the limits and collects the scores. This block also raises a clear pulse so that the score counters start the next interval from zero.

Top module: `mshr_throttle_ctl`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `done`, `ip_clear` and `lim_we` are low. No pair is stored and the repeat count is zero.
- R2: A high `eval_start` seen while idle starts an evaluation, and `busy` is high from the next cycle until `done` is shown. A high `eval_start` seen while busy is ignored and produces no extra `done`.
- R3: Scores are scanned one pair per cycle. `done` is a one-cycle pulse shown NPROC*NPROC+1 clock edges after the edge that sampled `eval_start`, and `ip_clear` pulses in the same cycle as `done`.
- R4: The pair index k equals interferer*NPROC + victim, and its score sits at bits [k*IPW +: IPW] of `ip_cnt`. The evaluation takes the largest score. When two or more scores tie, the lowest index wins.
- R5: A peak that is less than or equal to `ip_max_allowed` causes no write and leaves the stored pair and the repeat count unchanged.
- R6: A peak above the ceiling whose pair differs from the stored pair, or that arrives when no pair is stored, stores that pair and sets the repeat count to zero. It causes no write.
- R7: A peak above the ceiling from the stored pair, with a repeat count not greater than `rpt_thresh`, increments the repeat count. The count saturates at its maximum value. It causes no write.
- R8: A peak above the ceiling from the stored pair, with a repeat count greater than `rpt_thresh`, asserts the one-hot `lim_we` bit of the interferer together with `done`. `lim_val` is that processor's `cur_limit` minus one. The repeat count returns to zero and the pair stays stored.
- R9: A written limit is never below 1. A reduction of a processor whose current limit is 0 or 1 writes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eval_start | input | 1 | Request for an evaluation |
| ip_cnt | input | NPROC*NPROC*IPW | Interference scores, one field per pair, held stable while busy |
| ip_max_allowed | input | IPW | Ceiling; only a peak above it counts |
| rpt_thresh | input | RPTW | Repeat threshold that gates a reduction |
| cur_limit | input | NPROC*MSHRW | Current miss-slot limit per processor |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle pulse when the decision is made |
| ip_clear | output | 1 | One-cycle pulse that clears the score counters |
| lim_we | output | NPROC | One-hot write strobe for the reduced processor |
| lim_val | output | MSHRW | New limit that goes with `lim_we` |

## Verification
Two functions can land on the same decision edge. The first is the limit write to the culprit. The second is the restart of the repeat count that the same write causes. The bench provokes this by sending a pair above the ceiling through enough consecutive intervals, then checks that the very next interval with that pair counts again from zero and does not reduce twice. A second collision is a new start request that arrives while a scan is still running. The bench judges it by the absence of any extra `done` in a window after the genuine one.

// File: rtl/thr_pkg.sv
package thr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SCAN   = 2'd1,
    ST_DECIDE = 2'd2
  } thr_state_e;

  typedef enum logic [1:0] {
    ACT_NONE    = 2'd0,
    ACT_NEWPAIR = 2'd1,
    ACT_COUNT   = 2'd2,
    ACT_REDUCE  = 2'd3
  } thr_act_e;

endpackage

// File: rtl/ipt_max_scan.sv
module ipt_max_scan #(
  parameter int NPROC = 4,
  parameter int IPW   = 12
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              clr_en,
  input  logic                              step_en,
  input  logic [NPROC*NPROC*IPW-1:0]        ip_cnt,
  output logic [IPW-1:0]                    best_val,
  output logic [2*$clog2(NPROC)-1:0]        best_idx,
  output logic                              scan_last
);
  localparam int NPAIR = NPROC * NPROC;
  localparam int IW    = 2 * $clog2(NPROC);
  localparam logic [IW-1:0] LAST_IDX = IW'(NPAIR - 1);

  logic [IW-1:0]  idx_q, idx_d;
  logic [IPW-1:0] bval_q, bval_d;
  logic [IW-1:0]  bidx_q, bidx_d;
  logic [IPW-1:0] cand;
  logic           take;

  assign cand = ip_cnt[idx_q*IPW +: IPW];
  // strict compare keeps the earliest index on a tie
  assign take = (idx_q == '0) || (cand > bval_q);

  always_comb begin
    idx_d  = idx_q;
    bval_d = bval_q;
    bidx_d = bidx_q;
    if (clr_en) begin
      idx_d  = '0;
      bval_d = '0;
      bidx_d = '0;
    end else if (step_en) begin
      idx_d = (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
      if (take) begin
        bval_d = cand;
        bidx_d = idx_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      bval_q <= '0;
      bidx_q <= '0;
    end else if (clr_en || step_en) begin
      idx_q  <= idx_d;
      bval_q <= bval_d;
      bidx_q <= bidx_d;
    end
  end

  assign best_val  = bval_q;
  assign best_idx  = bidx_q;
  assign scan_last = step_en && (idx_q == LAST_IDX);

endmodule

// File: rtl/ipt_repeat_gate.sv
module ipt_repeat_gate
  import thr_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int IPW   = 12,
  parameter int RPTW  = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        eval_en,
  input  logic [IPW-1:0]              best_val,
  input  logic [2*$clog2(NPROC)-1:0]  best_idx,
  input  logic [IPW-1:0]              max_allowed,
  input  logic [RPTW-1:0]             rpt_thresh,
  output logic                        reduce,
  output logic [$clog2(NPROC)-1:0]    culprit
);
  localparam int PW = $clog2(NPROC);
  localparam int IW = 2 * PW;
  localparam logic [RPTW-1:0] RPT_MAX = '1;

  logic            vld_q, vld_d;
  logic [IW-1:0]   pair_q, pair_d;
  logic [RPTW-1:0] rpt_q, rpt_d;
  thr_act_e        act;
  logic            over;

  assign over = best_val > max_allowed;

  always_comb begin
    act = ACT_NONE;
    if (eval_en && over) begin
      if (vld_q && (best_idx == pair_q)) begin
        act = (rpt_q > rpt_thresh) ? ACT_REDUCE : ACT_COUNT;
      end else begin
        act = ACT_NEWPAIR;
      end
    end
  end

  always_comb begin
    vld_d  = vld_q;
    pair_d = pair_q;
    rpt_d  = rpt_q;
    unique case (act)
      ACT_NEWPAIR: begin
        vld_d  = 1'b1;
        pair_d = best_idx;
        rpt_d  = '0;
      end
      ACT_COUNT:  rpt_d = (rpt_q == RPT_MAX) ? rpt_q : rpt_q + 1'b1;
      ACT_REDUCE: rpt_d = '0;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      pair_q <= '0;
      rpt_q  <= '0;
    end else if (eval_en) begin
      vld_q  <= vld_d;
      pair_q <= pair_d;
      rpt_q  <= rpt_d;
    end
  end

  assign reduce  = (act == ACT_REDUCE);
  assign culprit = best_idx[IW-1:PW];

endmodule

// File: rtl/ipt_limit_step.sv
module ipt_limit_step #(
  parameter int NPROC = 4,
  parameter int MSHRW = 4
) (
  input  logic                      reduce,
  input  logic [$clog2(NPROC)-1:0]  culprit,
  input  logic [NPROC*MSHRW-1:0]    cur_limit,
  output logic [NPROC-1:0]          we_d,
  output logic [MSHRW-1:0]          val_d
);
  localparam logic [MSHRW-1:0] ONE = MSHRW'(1);

  logic [MSHRW-1:0] cur;

  assign cur = cur_limit[culprit*MSHRW +: MSHRW];

  for (genvar p = 0; p < NPROC; p++) begin : g_we
    assign we_d[p] = reduce && (culprit == p[$clog2(NPROC)-1:0]);
  end

  always_comb begin
    val_d = '0;
    if (reduce) begin
      val_d = (cur > ONE) ? cur - ONE : ONE;
    end
  end

endmodule

// File: rtl/mshr_throttle_ctl.sv
module mshr_throttle_ctl
  import thr_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int IPW   = 12,
  parameter int MSHRW = 4,
  parameter int RPTW  = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         eval_start,
  input  logic [NPROC*NPROC*IPW-1:0]   ip_cnt,
  input  logic [IPW-1:0]               ip_max_allowed,
  input  logic [RPTW-1:0]              rpt_thresh,
  input  logic [NPROC*MSHRW-1:0]       cur_limit,
  output logic                         busy,
  output logic                         done,
  output logic                         ip_clear,
  output logic [NPROC-1:0]             lim_we,
  output logic [MSHRW-1:0]             lim_val
);
  localparam int PW = $clog2(NPROC);
  localparam int IW = 2 * PW;

  thr_state_e       state_q, state_d;
  logic             start_en, scan_en, decide_en, scan_last;
  logic [IPW-1:0]   best_val;
  logic [IW-1:0]    best_idx;
  logic             reduce;
  logic [PW-1:0]    culprit;
  logic [NPROC-1:0] we_d;
  logic [MSHRW-1:0] val_d;
  logic             done_q, clr_q;
  logic [NPROC-1:0] we_q;
  logic [MSHRW-1:0] val_q;

  assign start_en  = (state_q == ST_IDLE) && eval_start;
  assign scan_en   = (state_q == ST_SCAN);
  assign decide_en = (state_q == ST_DECIDE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (eval_start) state_d = ST_SCAN;
      ST_SCAN:   if (scan_last)  state_d = ST_DECIDE;
      ST_DECIDE: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  ipt_max_scan #(.NPROC(NPROC), .IPW(IPW)) u_scan (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_en   (start_en),
    .step_en  (scan_en),
    .ip_cnt   (ip_cnt),
    .best_val (best_val),
    .best_idx (best_idx),
    .scan_last(scan_last)
  );

  ipt_repeat_gate #(.NPROC(NPROC), .IPW(IPW), .RPTW(RPTW)) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .eval_en    (decide_en),
    .best_val   (best_val),
    .best_idx   (best_idx),
    .max_allowed(ip_max_allowed),
    .rpt_thresh (rpt_thresh),
    .reduce     (reduce),
    .culprit    (culprit)
  );

  ipt_limit_step #(.NPROC(NPROC), .MSHRW(MSHRW)) u_step (
    .reduce   (reduce),
    .culprit  (culprit),
    .cur_limit(cur_limit),
    .we_d     (we_d),
    .val_d    (val_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      clr_q  <= 1'b0;
      we_q   <= '0;
      val_q  <= '0;
    end else begin
      done_q <= decide_en;
      clr_q  <= decide_en;
      we_q   <= we_d;
      val_q  <= val_d;
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign ip_clear = clr_q;
  assign lim_we   = we_q;
  assign lim_val  = val_q;

endmodule

// File: rtl/mshr_throttle_chk.sv
module mshr_throttle_chk #(
  parameter int NPROC = 4,
  parameter int IPW   = 12,
  parameter int MSHRW = 4,
  parameter int RPTW  = 3
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         eval_start,
  input logic [NPROC*MSHRW-1:0]       cur_limit,
  input logic                         busy,
  input logic                         done,
  input logic [NPROC-1:0]             lim_we,
  input logic [MSHRW-1:0]             lim_val
);
  localparam logic [MSHRW-1:0] ONE = MSHRW'(1);

  p_we_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lim_we));

  p_we_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_we != '0) |-> done);

  p_floor_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_we != '0) |-> (lim_val >= ONE));

  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(eval_start));

  p_done_after_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  for (genvar p = 0; p < NPROC; p++) begin : g_val
    p_step_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
      lim_we[p] |-> (lim_val == (($past(cur_limit[p*MSHRW +: MSHRW]) > ONE) ?
                                 $past(cur_limit[p*MSHRW +: MSHRW]) - ONE : ONE)));
  end

endmodule

bind mshr_throttle_ctl mshr_throttle_chk #(
  .NPROC(NPROC), .IPW(IPW), .MSHRW(MSHRW), .RPTW(RPTW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .eval_start(eval_start),
  .cur_limit (cur_limit),
  .busy      (busy),
  .done      (done),
  .lim_we    (lim_we),
  .lim_val   (lim_val)
);

// File: tb/sim_mshr_throttle_ctl.sv
`timescale 1ns/1ps
module sim_mshr_throttle_ctl;
  localparam int NPROC = 4;
  localparam int IPW   = 12;
  localparam int MSHRW = 4;
  localparam int RPTW  = 3;
  localparam int NPAIR = NPROC * NPROC;

  logic                        clk = 1'b0;
  logic                        rst_n;
  logic                        eval_start;
  logic [NPAIR*IPW-1:0]        ip_cnt;
  logic [IPW-1:0]              ip_max_allowed;
  logic [RPTW-1:0]             rpt_thresh;
  logic [NPROC*MSHRW-1:0]      cur_limit;
  logic                        busy, done, ip_clear;
  logic [NPROC-1:0]            lim_we;
  logic [MSHRW-1:0]            lim_val;

  always #4 clk = ~clk;

  mshr_throttle_ctl #(.NPROC(NPROC), .IPW(IPW), .MSHRW(MSHRW), .RPTW(RPTW)) u0 (
    .clk(clk), .rst_n(rst_n), .eval_start(eval_start), .ip_cnt(ip_cnt),
    .ip_max_allowed(ip_max_allowed), .rpt_thresh(rpt_thresh), .cur_limit(cur_limit),
    .busy(busy), .done(done), .ip_clear(ip_clear), .lim_we(lim_we), .lim_val(lim_val)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int n_done = 0;
  int t_start = 0;

  logic [IPW-1:0]   cnt [NPAIR];
  logic [MSHRW-1:0] lim [NPROC];

  // scoreboard queues
  logic [NPROC-1:0] q_we [$];
  logic [MSHRW-1:0] q_val [$];
  string            q_tag [$];

  // reference state
  bit              m_vld = 0;
  int              m_pair = 0;
  int              m_rpt = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        n_done++;
        if (q_we.size() == 0) begin
          check(1'b0, "R2 unexpected done", 1, 0);
        end else begin
          logic [NPROC-1:0] ew;
          logic [MSHRW-1:0] ev;
          string tg;
          ew = q_we.pop_front();
          ev = q_val.pop_front();
          tg = q_tag.pop_front();
          check(lim_we == ew, {tg, " lim_we"}, lim_we, ew);
          if (ew != '0) check(lim_val == ev, {tg, " lim_val"}, lim_val, ev);
          check(ip_clear == 1'b1, "R3 ip_clear with done", ip_clear, 1);
          check(cyc - t_start == NPAIR + 2, "R3 latency", cyc - t_start, NPAIR + 2);
          for (int p = 0; p < NPROC; p++) if (lim_we[p]) lim[p] = lim_val;
        end
      end else if (lim_we != '0) begin
        check(1'b0, "R8 write without done", lim_we, 0);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 150000) begin
      check(1'b0, "watchdog expired", cyc, 0);
      finish_run();
    end
  end

  task automatic clear_cnt();
    for (int k = 0; k < NPAIR; k++) cnt[k] = '0;
  endtask

  task automatic run_eval(input int thr, input int maxa, input string tag, input bit extra);
    int bv, bi, target;
    logic [NPROC-1:0] ew;
    logic [MSHRW-1:0] ev;
    bv = 0; bi = 0; ew = '0; ev = '0;
    for (int k = 0; k < NPAIR; k++) begin
      if (k == 0 || int'(cnt[k]) > bv) begin
        bv = int'(cnt[k]);
        bi = k;
      end
    end
    if (bv > maxa) begin
      if (m_vld && bi == m_pair) begin
        if (m_rpt > thr) begin
          int p;
          p = bi / NPROC;
          ew[p] = 1'b1;
          ev = (lim[p] > 1) ? lim[p] - 1'b1 : MSHRW'(1);
          m_rpt = 0;
        end else if (m_rpt < (1 << RPTW) - 1) begin
          m_rpt++;
        end
      end else begin
        m_vld = 1; m_pair = bi; m_rpt = 0;
      end
    end
    q_we.push_back(ew);
    q_val.push_back(ev);
    q_tag.push_back(tag);
    @(negedge clk);
    for (int k = 0; k < NPAIR; k++) ip_cnt[k*IPW +: IPW] = cnt[k];
    for (int p = 0; p < NPROC; p++) cur_limit[p*MSHRW +: MSHRW] = lim[p];
    ip_max_allowed = IPW'(maxa);
    rpt_thresh = RPTW'(thr);
    eval_start = 1'b1;
    t_start = cyc;
    target = n_done + 1;
    @(negedge clk);
    eval_start = 1'b0;
    check(busy == 1'b1, "R2 busy after start", busy, 1);
    if (extra) begin
      repeat (4) @(negedge clk);
      eval_start = 1'b1;
      @(negedge clk);
      eval_start = 1'b0;
    end
    while (n_done < target) @(negedge clk);
    @(negedge clk);
    check(busy == 1'b0, "R2 idle after done", busy, 0);
    if (extra) begin
      repeat (NPAIR + 6) @(negedge clk);
      check(n_done == target, "R2 start while busy ignored", n_done, target);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    eval_start = 1'b0;
    ip_cnt = '0;
    ip_max_allowed = '0;
    rpt_thresh = '0;
    cur_limit = '0;
    for (int p = 0; p < NPROC; p++) lim[p] = MSHRW'(8);
    clear_cnt();
    repeat (3) @(negedge clk);
    check({busy, done, ip_clear, lim_we} == '0, "R1 outputs in reset", {busy, done, ip_clear, lim_we}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({busy, done, ip_clear, lim_we} == '0, "R1 outputs after reset", {busy, done, ip_clear, lim_we}, 0);

    // all quiet: nothing happens
    run_eval(1, 10, "R5 all zero", 0);
    // first excess stores pair (interferer 2, victim 1)
    cnt[9] = 12'd50;
    run_eval(1, 10, "R6 first excess", 0);
    run_eval(1, 10, "R7 repeat one", 0);
    // below ceiling: pair and count held
    cnt[9] = 12'd5;
    run_eval(1, 10, "R5 below ceiling", 0);
    cnt[9] = 12'd10;
    run_eval(1, 10, "R5 equal to ceiling", 0);
    cnt[9] = 12'd50;
    run_eval(1, 10, "R7 repeat two", 0);
    run_eval(1, 10, "R8 reduce proc2", 0);
    // write and counter restart share a cycle: next one only counts
    run_eval(1, 10, "R8 count restarts", 0);
    // tie between index 3 and 9: index 3 wins, new pair
    cnt[3] = 12'd60; cnt[9] = 12'd60;
    run_eval(0, 10, "R4 tie lowest index", 0);
    run_eval(0, 10, "R7 thresh zero count", 0);
    run_eval(0, 10, "R8 reduce proc0", 0);
    // floor at one
    lim[0] = MSHRW'(1);
    run_eval(0, 10, "R7 before floor", 0);
    run_eval(0, 10, "R9 floor from one", 0);
    lim[0] = MSHRW'(0);
    run_eval(0, 10, "R7 before floor zero", 0);
    run_eval(0, 10, "R9 floor from zero", 0);
    // last index beats index 0
    clear_cnt();
    cnt[0] = 12'd69; cnt[15] = 12'd70;
    run_eval(2, 10, "R4 last index max", 0);
    // start while busy
    run_eval(2, 10, "R2 busy ignore", 1);
    repeat (4) @(negedge clk);
    check(q_we.size() == 0, "R3 all results seen", q_we.size(), 0);
    finish_run();
  end

endmodule